// File: doc/BRIEF.md
# Posted Column Command Latency Scheduler

This block sits between a memory device's command decoder and its column logic. Read and write column commands may be posted on any cycle, including the cycle right after a row activate. Each command is held for a programmable additive latency (AL) and then released as an internal column command. The command keeps its direction, its auto-precharge flag, its bank and its column. The block also produces two timing pulses for the data path. The read pulse marks the cycle in which read data becomes valid, at read latency RL = AL + CL. The write pulse marks the cycle in which write data is expected, at write latency WL = AL + CWL.

AL is chosen with a two-bit selector, as zero or as an offset below CL. The CAS latency (CL) and the CAS write latency (CWL) are register settings supplied on input ports. Changing any of these settings while a command is still pending is illegal. The block flags it with an error bit that stays set until reset.

Top module: `posted_cas_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `int_valid`, `rd_data_valid`, `wr_data_expect` and `cfg_err` are all low.
- R2: A command with `cmd_valid` high in cycle t appears on `int_valid`/`int_write`/`int_bank`/`int_col` in cycle t+AL, with the same write flag, bank and column. No other cycle shows `int_valid` high.
- R3: `al_sel` selects AL: 0 gives 0, 1 gives CL-1, 2 gives CL-2, and 3 is treated as 0. When AL is 0 the command reaches the internal outputs in the same cycle, through logic only. CL must lie between 3 and 2^LAT_W-1, and CWL between 1 and 2^LAT_W-1.
- R4: The auto-precharge flag `cmd_ap` is carried to `int_ap` unchanged, for both reads and writes.
- R5: Each read accepted in cycle t (`cmd_write`=0) makes `rd_data_valid` high in cycle t+AL+CL. Cycles without such a read have it low.
- R6: Each write accepted in cycle t (`cmd_write`=1) makes `wr_data_expect` high in cycle t+AL+CWL. Cycles without such a write have it low.
- R7: Commands posted on every cycle leave in order, one per cycle, with none lost. The read pulse and the write pulse of different commands may fall in the same cycle.
- R8: If `al_sel`, `cl` or `cwl` changes while any accepted command is still within the latency window, `cfg_err` rises one cycle later and stays high until reset. A change made once the block has been idle for 2^(LAT_W+1)-3 cycles leaves `cfg_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A column command is posted this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_ap | input | 1 | Auto-precharge requested |
| cmd_bank | input | BANK_W | Target bank |
| cmd_col | input | COL_W | Column address |
| al_sel | input | 2 | Additive latency selector |
| cl | input | LAT_W | CAS latency setting |
| cwl | input | LAT_W | CAS write latency setting |
| int_valid | output | 1 | Internal column command issued |
| int_write | output | 1 | Direction of the internal command |
| int_ap | output | 1 | Auto-precharge flag of the internal command |
| int_bank | output | BANK_W | Bank of the internal command |
| int_col | output | COL_W | Column of the internal command |
| rd_data_valid | output | 1 | Read data valid pulse at RL |
| wr_data_expect | output | 1 | Write data expected pulse at WL |
| cfg_err | output | 1 | Sticky illegal-setting-change flag |

## Verification
Three outputs can become active in the same cycle, because they are driven by different commands: the internal command of a recent post, the read pulse of an older read and the write pulse of an older write. This is provoked by streams of mixed reads and writes, both dense (a post on every cycle) and sparse (pseudo-random). The streams are swept over every AL selector and over several CL and CWL values, so RL and WL differ and their windows overlap. In every cycle the bench compares all three outputs at once against per-cycle expectations, which it computes arithmetically from the issue cycle, AL, CL and CWL.

// File: rtl/posted_cas_sched.sv
module posted_cas_sched #(
  parameter int COL_W  = 10,
  parameter int BANK_W = 3,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic              cmd_ap,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [1:0]        al_sel,
  input  logic [LAT_W-1:0]  cl,
  input  logic [LAT_W-1:0]  cwl,
  output logic              int_valid,
  output logic              int_write,
  output logic              int_ap,
  output logic [BANK_W-1:0] int_bank,
  output logic [COL_W-1:0]  int_col,
  output logic              rd_data_valid,
  output logic              wr_data_expect,
  output logic              cfg_err
);

  localparam int LAT_MAX  = (1 << LAT_W) - 1;
  localparam int AL_MAX   = LAT_MAX - 1;
  localparam int LINE_LEN = AL_MAX + LAT_MAX;
  localparam int CFG_W    = 2 + 2 * LAT_W;

  typedef struct packed {
    logic              v;
    logic              w;
    logic              ap;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
  } slot_t;

  slot_t in_slot, out_slot;
  slot_t pipe [AL_MAX];

  logic [LAT_W-1:0]    al;
  logic [LAT_W:0]      rl, wl;
  logic [LINE_LEN-1:0] rd_line, wr_line;
  logic [CFG_W-1:0]    cfg_now, cfg_q;
  logic                busy;

  always_comb begin
    case (al_sel)
      2'd1:    al = cl - LAT_W'(1);
      2'd2:    al = cl - LAT_W'(2);
      default: al = '0;
    endcase
  end

  assign rl = {1'b0, al} + {1'b0, cl};
  assign wl = {1'b0, al} + {1'b0, cwl};

  assign in_slot = '{v: cmd_valid, w: cmd_write, ap: cmd_ap, bank: cmd_bank, col: cmd_col};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < AL_MAX; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= in_slot;
      for (int i = 1; i < AL_MAX; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign out_slot  = (al == '0) ? in_slot : pipe[al - LAT_W'(1)];
  assign int_valid = out_slot.v;
  assign int_write = out_slot.w;
  assign int_ap    = out_slot.ap;
  assign int_bank  = out_slot.bank;
  assign int_col   = out_slot.col;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_line <= '0;
      wr_line <= '0;
    end else begin
      rd_line <= {rd_line[LINE_LEN-2:0], cmd_valid & ~cmd_write};
      wr_line <= {wr_line[LINE_LEN-2:0], cmd_valid & cmd_write};
    end
  end

  assign rd_data_valid  = (rl != '0) && rd_line[rl - 1'b1];
  assign wr_data_expect = (wl != '0) && wr_line[wl - 1'b1];

  assign cfg_now = {al_sel, cl, cwl};
  assign busy    = (|rd_line) | (|wr_line);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= cfg_now;
      cfg_err <= 1'b0;
    end else begin
      cfg_q <= cfg_now;
      if (busy && (cfg_now != cfg_q)) cfg_err <= 1'b1;
    end
  end

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (al == '0 && cmd_valid) |-> int_valid);  // R3

  AST_AP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (al == '0 && cmd_valid) |-> (int_ap == cmd_ap && int_write == cmd_write));  // R4

  AST_AL1_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (al == LAT_W'(1) && $past(al) == LAT_W'(1) && $past(rst_n)) |-> (int_valid == $past(cmd_valid)));  // R2

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);  // R8

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> ($past(cfg_now) != $past(cfg_now, 2)));  // R8

endmodule

// File: tb/posted_cas_sched_tb.sv
module posted_cas_sched_tb;
  localparam int COL_W = 10, BANK_W = 3, LAT_W = 4, RUN = 80, POST = 40;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_write = 0, cmd_ap = 0;
  logic [BANK_W-1:0] cmd_bank = '0;
  logic [COL_W-1:0]  cmd_col = '0;
  logic [1:0] al_sel = 0;
  logic [LAT_W-1:0] cl = 4'd5, cwl = 4'd5;
  logic int_valid, int_write, int_ap, rd_data_valid, wr_data_expect, cfg_err;
  logic [BANK_W-1:0] int_bank;
  logic [COL_W-1:0]  int_col;

  int checks = 0, errors = 0;
  logic [31:0] seed = 32'h1234_5678;
  bit e_v[RUN], e_w[RUN], e_ap[RUN], e_rd[RUN], e_wr[RUN];
  int e_bank[RUN], e_col[RUN];

  always #5 clk = ~clk;

  posted_cas_sched #(.COL_W(COL_W), .BANK_W(BANK_W), .LAT_W(LAT_W)) u_dut (
    .clk, .rst_n, .cmd_valid, .cmd_write, .cmd_ap, .cmd_bank, .cmd_col,
    .al_sel, .cl, .cwl, .int_valid, .int_write, .int_ap, .int_bank, .int_col,
    .rd_data_valid, .wr_data_expect, .cfg_err);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int al_of(input int sel, input int c);
    return (sel == 1) ? c - 1 : (sel == 2) ? c - 2 : 0;
  endfunction

  task automatic run_stream(input int sel, input int c, input int cw, input bit dense);
    int al;
    al = al_of(sel, c);
    for (int i = 0; i < RUN; i++) begin
      e_v[i] = 0; e_w[i] = 0; e_ap[i] = 0; e_rd[i] = 0; e_wr[i] = 0; e_bank[i] = 0; e_col[i] = 0;
    end
    @(negedge clk);
    al_sel = 2'(sel); cl = LAT_W'(c); cwl = LAT_W'(cw);
    for (int t = 0; t < RUN; t++) begin
      if (t > 0) @(negedge clk);
      seed = seed * 32'd1103515245 + 32'd12345;
      cmd_valid = (t < POST) && (dense || seed[16]);
      cmd_write = seed[20];
      cmd_ap    = seed[23];
      cmd_bank  = BANK_W'(seed[31:25]);
      cmd_col   = COL_W'(seed[30:17] ^ 14'(t));
      if (cmd_valid) begin
        e_v[t+al] = 1; e_w[t+al] = cmd_write; e_ap[t+al] = cmd_ap;
        e_bank[t+al] = int'(cmd_bank); e_col[t+al] = int'(cmd_col);
        if (cmd_write) e_wr[t+al+cw] = 1; else e_rd[t+al+c] = 1;
      end
      #1;
      check(int_valid == e_v[t], "R2/R3/R7 int_valid", int'(int_valid), int'(e_v[t]));
      if (e_v[t]) begin
        check(int_write == e_w[t] && int'(int_bank) == e_bank[t] && int'(int_col) == e_col[t],
              "R2/R7 fields", int'({int_write, int_bank, int_col}), (int'(e_w[t]) << 13) | (e_bank[t] << 10) | e_col[t]);
        check(int_ap == e_ap[t], "R4 int_ap", int'(int_ap), int'(e_ap[t]));
      end
      check(rd_data_valid == e_rd[t], "R5 rd_data_valid", int'(rd_data_valid), int'(e_rd[t]));
      check(wr_data_expect == e_wr[t], "R6 wr_data_expect", int'(wr_data_expect), int'(e_wr[t]));
    end
    cmd_valid = 0;
    check(cfg_err == 0, "R8 idle change", int'(cfg_err), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({int_valid, rd_data_valid, wr_data_expect, cfg_err} == 4'b0, "R1 in reset", 0, 0);
    rst_n = 1;
    @(negedge clk); #1;
    check({int_valid, rd_data_valid, wr_data_expect, cfg_err} == 4'b0, "R1 after reset",
          int'({int_valid, rd_data_valid, wr_data_expect, cfg_err}), 0);
    for (int sel = 0; sel < 4; sel++)
      for (int ci = 0; ci < 3; ci++)
        for (int wi = 0; wi < 2; wi++)
          for (int d = 0; d < 2; d++)
            run_stream(sel, 3 + 2 * ci, (wi == 0) ? 2 : 5, d[0]);
    run_stream(1, 15, 15, 1);
    run_stream(2, 15, 1, 0);
    // R8: setting change while a command is pending
    @(negedge clk);
    al_sel = 2'd1; cl = 4'd7; cwl = 4'd5;
    @(negedge clk);
    cmd_valid = 1; cmd_write = 0;
    @(negedge clk);
    cmd_valid = 0; cl = 4'd6;
    @(negedge clk); #1;
    check(cfg_err == 1, "R8 busy change", int'(cfg_err), 1);
    cl = 4'd7;
    repeat (40) @(negedge clk);
    #1;
    check(cfg_err == 1, "R8 sticky", int'(cfg_err), 1);
    rst_n = 0;
    @(negedge clk); #1;
    check({int_valid, rd_data_valid, wr_data_expect, cfg_err} == 4'b0, "R1 re-reset",
          int'({int_valid, rd_data_valid, wr_data_expect, cfg_err}), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule